// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port Controller

This block is a serial test access port for board interconnect test. It takes a test clock, a mode-select line and a serial data input, and drives one serial data output. The standard sixteen-state port controller steers the serial path either through a 3-bit instruction register or through one of three data registers. The data registers are a 1-bit bypass stage, a 32-bit identification register and a 70-cell boundary register. The block has no dedicated test-reset pin. The controller returns to its reset state through the mode-select line, and the active-low input `rst_ni` stands in for power-up.

The boundary register can only capture. Each cell samples one bit of a parallel pad vector in Capture-DR, and the chain then shifts out, cell 0 first. Two cell positions are placeholders that always capture zero. There is no drive-from-scan and no preload of the chain. Two instruction groups select the boundary register. One group samples only. The other also asks the functional data drivers to go high impedance for as long as it is the active instruction. Every other opcode selects either the identification register or the bypass stage. The serial output changes on the falling test-clock edge, and it is driven only while a shift state is active.

Top module: `scan_port`

## Requirements
- R1: Five or more consecutive rising edges with `tms_i` high put the controller in Test-Logic-Reset from any state. The active instruction then becomes IDCODE (3'b001).
- R2: The state sequence follows the standard sixteen-state diagram. A Shift-DR that is interrupted through Exit1-DR, Pause-DR and Exit2-DR and then resumed gives the same serial result as an uninterrupted shift.
- R3: The instruction shift register loads 3'b001 in Capture-IR, so the bits leaving `tdo_o` are 1, 0, 0. Instruction bits are shifted in LSB first, and the new instruction takes effect in Update-IR.
- R4: Opcode 3'b001 selects the 32-bit identification register. Its contents leave LSB first, and after that the bits applied at `tdi_i` come out delayed by 32 clocks.
- R5: Opcodes 3'b011, 3'b101, 3'b111 and the reserved 3'b110 select the 1-bit bypass stage. That stage captures 0 and delays `tdi_i` by one clock.
- R6: Opcode 3'b100 selects the 70-cell boundary register. In Capture-DR cell k loads `pad_cap_i[k]`, and cell 0 leaves `tdo_o` first.
- R7: Opcodes 3'b000 and 3'b010 act on the boundary register in the same way as R6. `drv_hiz_o` is high exactly while one of them is the active instruction. It rises only on leaving Update-IR.
- R8: `tdo_o` and `tdo_oe_o` change only on falling edges of `tck_i`.
- R9: `tdo_oe_o` is high only in Shift-DR and Shift-IR, and `tdo_o` is high impedance otherwise. Both are low after reset.
- R10: The identification value is 32'h0390_000F: revision 4'h0 in [31:28], configuration 10'b0011100100 in [27:18], zero in [17:12], code 11'b00000000111 in [11:1], and 1 in [0].
- R11: Boundary cells 53 and 54 are placeholders and capture 0 whatever the pad input holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| tms_i | input | 1 | Mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in, sampled on rising `tck_i` |
| pad_cap_i | input | 70 | Parallel pad values captured by the boundary cells |
| tdo_o | output | 1 | Serial data out, high impedance when not shifting |
| tdo_oe_o | output | 1 | Serial output enable |
| drv_hiz_o | output | 1 | Request to tri-state the functional data drivers |

## Verification
Several properties are checked by assertions on every cycle:
- the five-high reset rule, counted with a run-length counter;
- the fixed Capture-IR pattern seen at the serial output;
- the instruction returning to IDCODE after Test-Logic-Reset;
- the output enable tracking the shift states;
- `drv_hiz_o` rising only out of Update-IR, and only for the two sampling-with-tri-state opcodes.

Chain selection, chain lengths, the identification value, the placeholder cells and pause-and-resume shifting cannot be expressed as simple properties. The bench shows them by sweeping all eight opcodes over several pad patterns. It compares whole serial streams with values it computes itself.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

  localparam int unsigned IR_W = 3;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic dr_path_e path_of(input logic [IR_W-1:0] op);
    unique case (op)
      3'b001:                 return PATH_ID;
      3'b000, 3'b010, 3'b100: return PATH_BSR;
      default:                return PATH_BYP; // includes reserved 3'b110
    endcase
  endfunction

  function automatic logic hiz_of(input logic [IR_W-1:0] op);
    return (op == 3'b000) || (op == 3'b010);
  endfunction
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import scan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms_i ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/scan_ir.sv
`timescale 1ns/1ps
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  output logic            lsb_o,
  output logic [IR_W-1:0] instr_o
);
  logic [IR_W-1:0] sr_q, instr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= IR_CAPTURE;
      instr_q <= OP_IDCODE;
    end else begin
      unique case (state_i)
        ST_RESET:  instr_q <= OP_IDCODE;
        ST_CAP_IR: sr_q    <= IR_CAPTURE;
        ST_SH_IR:  sr_q    <= {tdi_i, sr_q[IR_W-1:1]};
        ST_UPD_IR: instr_q <= sr_q;
        default: ;
      endcase
    end
  end

  assign lsb_o   = sr_q[0];
  assign instr_o = instr_q;
endmodule

// File: rtl/scan_dr.sv
`timescale 1ns/1ps
module scan_dr
  import scan_pkg::*;
#(
  parameter int unsigned      BSR_LEN = 70,
  parameter int unsigned      ID_W    = 32,
  parameter logic [ID_W-1:0]  ID_VAL  = 32'h0390_000F,
  parameter logic [BSR_LEN-1:0] PH_MASK = 70'h0
)(
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tdi_i,
  input  tap_state_e         state_i,
  input  dr_path_e           path_i,
  input  logic [BSR_LEN-1:0] pad_cap_i,
  output logic               lsb_o
);
  logic cap, sh;
  assign cap = (state_i == ST_CAP_DR);
  assign sh  = (state_i == ST_SH_DR);

  // bypass stage
  logic byp_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          byp_q <= 1'b0;
    else if (path_i == PATH_BYP && cap)   byp_q <= 1'b0;
    else if (path_i == PATH_BYP && sh)    byp_q <= tdi_i;
  end

  // identification register
  logic [ID_W-1:0] id_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                        id_q <= ID_VAL;
    else if (path_i == PATH_ID && cap)  id_q <= ID_VAL;
    else if (path_i == PATH_ID && sh)   id_q <= {tdi_i, id_q[ID_W-1:1]};
  end

  // boundary cells, capture-only
  logic [BSR_LEN-1:0] bsr_q;
  logic bsr_cap, bsr_sh;
  assign bsr_cap = (path_i == PATH_BSR) && cap;
  assign bsr_sh  = (path_i == PATH_BSR) && sh;

  for (genvar k = 0; k < BSR_LEN; k++) begin : g_cell
    logic shin, capv;
    if (k == BSR_LEN-1) begin : g_tail
      assign shin = tdi_i;
    end else begin : g_mid
      assign shin = bsr_q[k+1];
    end
    if (PH_MASK[k]) begin : g_ph
      assign capv = 1'b0;
    end else begin : g_pad
      assign capv = pad_cap_i[k];
    end
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)      bsr_q[k] <= 1'b0;
      else if (bsr_cap) bsr_q[k] <= capv;
      else if (bsr_sh)  bsr_q[k] <= shin;
    end
  end

  always_comb begin
    unique case (path_i)
      PATH_ID:  lsb_o = id_q[0];
      PATH_BSR: lsb_o = bsr_q[0];
      default:  lsb_o = byp_q;
    endcase
  end
endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
module scan_port
  import scan_pkg::*;
#(
  parameter int unsigned        BSR_LEN = 70,
  parameter int unsigned        ID_W    = 32,
  parameter logic [ID_W-1:0]    ID_VAL  = {4'h0, 10'b0011100100, 6'b0, 11'b00000000111, 1'b1},
  parameter logic [BSR_LEN-1:0] PH_MASK = (70'h1 << 53) | (70'h1 << 54)
)(
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pad_cap_i,
  output logic               tdo_o,
  output logic               tdo_oe_o,
  output logic               drv_hiz_o
);
  tap_state_e      state;
  logic [IR_W-1:0] instr;
  logic            ir_lsb, dr_lsb;
  dr_path_e        path;

  tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  scan_ir u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tdi_i   (tdi_i),
    .state_i (state),
    .lsb_o   (ir_lsb),
    .instr_o (instr)
  );

  assign path = path_of(instr);

  scan_dr #(
    .BSR_LEN (BSR_LEN),
    .ID_W    (ID_W),
    .ID_VAL  (ID_VAL),
    .PH_MASK (PH_MASK)
  ) u_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .tdi_i     (tdi_i),
    .state_i   (state),
    .path_i    (path),
    .pad_cap_i (pad_cap_i),
    .lsb_o     (dr_lsb)
  );

  // output stage launches on the falling edge
  logic tdo_q, oe_q;
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == ST_SH_DR) || (state == ST_SH_IR);
      tdo_q <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
    end
  end

  assign tdo_o     = oe_q ? tdo_q : 1'bz;
  assign tdo_oe_o  = oe_q;
  assign drv_hiz_o = hiz_of(instr);
endmodule

// File: rtl/scan_port_chk.sv
`timescale 1ns/1ps
module scan_port_chk
  import scan_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input logic            tdo_o,
  input logic            tdo_oe_o,
  input logic            drv_hiz_o,
  input tap_state_e      state,
  input logic [IR_W-1:0] instr
);
  logic [2:0] run_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 3'd0;
    else if (!tms_i)      run_q <= 3'd0;
    else if (run_q < 3'd5) run_q <= run_q + 3'd1;
  end

  p_tms_reset_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (run_q == 3'd5) |-> (state == ST_RESET));

  p_idcode_after_reset_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_RESET) |=> (instr == OP_IDCODE));

  p_ir_capture_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_SH_IR && $past(state) == ST_CAP_IR) |-> (tdo_oe_o && tdo_o == 1'b1));

  p_hiz_rise_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(drv_hiz_o) |-> ($past(state) == ST_UPD_IR));

  p_hiz_ops_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    drv_hiz_o |-> (instr == 3'b000 || instr == 3'b010));

  p_oe_shift_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (state == ST_SH_DR || state == ST_SH_IR));

  p_oe_stable_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_SH_DR && $past(state) == ST_SH_DR) |-> tdo_oe_o);
endmodule

bind scan_port scan_port_chk u_chk (
  .tck_i     (tck_i),
  .rst_ni    (rst_ni),
  .tms_i     (tms_i),
  .tdo_o     (tdo_o),
  .tdo_oe_o  (tdo_oe_o),
  .drv_hiz_o (drv_hiz_o),
  .state     (state),
  .instr     (instr)
);

// File: tb/sim_scan_port.sv
`timescale 1ns/1ps
module sim_scan_port;
  localparam int L = 70;
  localparam int N = 80;
  localparam logic [31:0] EXP_ID = 32'h0390_000F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tms = 1'b1, tdi = 1'b0;
  logic [L-1:0] pads = '0;
  wire tdo, tdo_oe, hiz;

  always #5 clk = ~clk;

  scan_port u0 (
    .tck_i(clk), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi),
    .pad_cap_i(pads), .tdo_o(tdo), .tdo_oe_o(tdo_oe), .drv_hiz_o(hiz)
  );

  int checks = 0, fails = 0;
  int oe_bad = 0, edge_bad = 0;
  logic s_tdo;
  logic [N-1:0] dout;
  logic [2:0] irout;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one TCK cycle: sample after falling edge, drive, then cross rising edge
  task automatic step(input logic m, input logic d, input logic exp_oe);
    logic pre;
    @(negedge clk); #1;
    s_tdo = tdo;
    if (tdo_oe !== exp_oe) oe_bad++;
    tms = m; tdi = d;
    #3; pre = tdo;
    @(posedge clk); #1;
    if (tdo !== pre) edge_bad++;
  endtask

  task automatic load_ir(input logic [2:0] op);
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], 1);
      irout[i] = s_tdo;
    end
    step(1, 0, 0); step(0, 0, 0);
  endtask

  function automatic logic tdi_pat(input int k);
    return ((k % 3) == 0) ^ ((k % 7) == 2);
  endfunction

  task automatic scan_dr(input int pause_at);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int k = 0; k < N; k++) begin
      step((k == N-1) || (k == pause_at), tdi_pat(k), 1);
      dout[k] = s_tdo;
      if (k == pause_at) begin
        step(0, 0, 0); step(0, 0, 0); step(1, 0, 0); step(0, 0, 0);
      end
    end
    step(1, 0, 0); step(0, 0, 0);
  endtask

  function automatic logic [N-1:0] expect_stream(input int len, input logic [L-1:0] cap);
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) e[k] = (k < len) ? cap[k] : tdi_pat(k - len);
    return e;
  endfunction

  function automatic logic [L-1:0] masked(input logic [L-1:0] p);
    logic [L-1:0] r = p;
    r[53] = 1'b0; r[54] = 1'b0;
    return r;
  endfunction

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [L-1:0] pat [3];
    logic [L-1:0] id_cap;
    for (int k = 0; k < L; k++) begin
      pat[0][k] = 1'b1;
      pat[1][k] = k[0];
      pat[2][k] = ((k * 7 + 3) % 5) < 2;
    end
    id_cap = '0; id_cap[31:0] = EXP_ID;

    #12;
    chk(tdo_oe == 1'b0, "R9 reset oe", 128'(tdo_oe), 0);
    chk(hiz == 1'b0, "R7 reset hiz", 128'(hiz), 0);
    rst_n = 1'b1;
    step(0, 0, 0);

    scan_dr(-1);
    chk(dout == expect_stream(32, id_cap), "R10 R4 idcode after reset", 128'(dout), 128'(expect_stream(32, id_cap)));

    load_ir(3'b001);
    chk(irout == 3'b001, "R3 capture pattern", 128'(irout), 128'(3'b001));

    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 3; p++) begin
        int len;
        logic [L-1:0] cap;
        logic [N-1:0] e;
        pads = pat[p];
        load_ir(3'(op));
        if (op == 1) begin len = 32; cap = id_cap; end
        else if (op == 0 || op == 2 || op == 4) begin len = L; cap = masked(pat[p]); end
        else begin len = 1; cap = '0; end
        scan_dr(-1);
        e = expect_stream(len, cap);
        if (op == 1)      chk(dout == e, "R4 idcode stream", 128'(dout), 128'(e));
        else if (op == 4) chk(dout == e, "R6 sample stream", 128'(dout), 128'(e));
        else if (len == L) chk(dout == e, "R7 sample-z stream", 128'(dout), 128'(e));
        else              chk(dout == e, "R5 bypass stream", 128'(dout), 128'(e));
        if (len == L)
          chk(dout[54:53] == 2'b00, "R11 placeholder cells", 128'(dout[54:53]), 0);
        chk(hiz == (op == 0 || op == 2), "R7 driver hiz per opcode", 128'(hiz), 128'(op == 0 || op == 2));
        chk(irout == 3'b001, "R3 capture per load", 128'(irout), 128'(3'b001));
      end
    end

    // pause and resume in the middle of a shift
    pads = pat[2];
    load_ir(3'b100);
    scan_dr(20);
    chk(dout == expect_stream(L, masked(pat[2])), "R2 pause resume sample", 128'(dout), 128'(expect_stream(L, masked(pat[2]))));
    load_ir(3'b001);
    scan_dr(5);
    chk(dout == expect_stream(32, id_cap), "R2 pause resume idcode", 128'(dout), 128'(expect_stream(32, id_cap)));

    // five-high reset out of Shift-DR after selecting bypass
    load_ir(3'b011);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, i == 0);
    step(0, 0, 0);
    scan_dr(-1);
    chk(dout == expect_stream(32, id_cap), "R1 reset from shift-dr", 128'(dout), 128'(expect_stream(32, id_cap)));

    // five-high reset clears the tri-state request
    load_ir(3'b010);
    chk(hiz == 1'b1, "R7 hiz set", 128'(hiz), 1);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    chk(hiz == 1'b0, "R1 hiz cleared by reset", 128'(hiz), 0);
    step(0, 0, 0);

    chk(oe_bad == 0, "R9 oe only in shift", 128'(oe_bad), 0);
    chk(edge_bad == 0, "R8 tdo stable at rising edge", 128'(edge_bad), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule